// File: doc/BRIEF.md
# Read-to-Take Semaphore Bank

This block holds a small set of one-bit semaphores that a host processor and an internal task engine use to guard shared parameter storage. The host reaches the bank through a plain register port. Reading a semaphore address does two things at once. It takes the semaphore if it is free, and it reports whether the take worked. Writing a one to the address gives the semaphore back.

The task engine does not use the register port. It drives three strobes: task start, setup complete and task end. On task start it claims semaphore 0. On setup complete it claims semaphore 1. On task end it hands back whatever it obtained. If either claim finds the semaphore already held, a sticky error flag is raised. The host can read this flag and clear it at a status address.

The highest semaphores (semaphore 2 with the default count) are never touched by the engine. They serve purely as host-to-host locks.

Top module: `sem_bank`

## Requirements
- R1: After reset every semaphore is free (value 1), the error flag is 0, and `host_rdata` and `host_rvalid` are 0.
- R2: A host read (`host_req`=1, `host_we`=0) of semaphore address 0..N_SEM-1 sets `host_rvalid` one cycle later. In that cycle `host_rdata` bit 0 holds the semaphore value and all other bits are 0. After the read the semaphore is 0, so a successful reader keeps getting 0 until a release.
- R3: A host read that returns 0 changes no state: the semaphore stays held and the error flag is unchanged.
- R4: A host write to a semaphore address with `wdata` bit 0 = 1 frees that semaphore. A write with bit 0 = 0 has no effect.
- R5: A `task_start` pulse makes the engine take semaphore 0 if it is free. A `setup_done` pulse makes it take semaphore 1 if it is free.
- R6: A `task_end` pulse frees exactly the semaphores the engine obtained. A `task_start` or `setup_done` in the same cycle as `task_end` makes no take.
- R7: An engine take that finds its semaphore held sets the error flag one cycle later and leaves ownership unchanged.
- R8: The error flag is sticky. A host read of address N_SEM returns it in bit 0 without clearing it. A host write to address N_SEM clears it. A new refusal in the same cycle as a clear wins.
- R9: When a host read and an engine take hit the same free semaphore in one cycle, the engine gets it and the host read returns 0.
- R10: Semaphores at index 2 and above are host-only: the engine strobes never take or free them.
- R11: The `err_flag` port shows the error flag state with no combinational path from the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | 0..N_SEM-1 semaphores, N_SEM status |
| host_wdata | input | DATA_W | Write data, bit 0 significant |
| host_rdata | output | DATA_W | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after a read |
| task_start | input | 1 | Engine: task begins, claim semaphore 0 |
| setup_done | input | 1 | Engine: setup complete, claim semaphore 1 |
| task_end | input | 1 | Engine: task over, hand back holdings |
| err_flag | output | 1 | Sticky refused-claim flag |

## Verification
The bench builds the block with its defaults: three semaphores, an 8-bit data path and a 2-bit address. With these values one address is left over for status, and there is exactly one host-only semaphore, so R10 is exercised through index 2. The directed tests cover several same-cycle cases:
- an engine claim racing a host read;
- a task end arriving with a task start;
- a refusal racing a status clear.

A refusal against a host-held semaphore is also checked by reading ownership back at the port after the task ends.

// File: rtl/sem_pkg.sv
package sem_pkg;
  // number of semaphores the task engine claims (indices 0 .. ENG_SEMS-1)
  localparam int ENG_SEMS = 2;
  // engine claim order: start phase claims 0, setup phase claims 1
  localparam int START_IDX = 0;
  localparam int SETUP_IDX = 1;
endpackage

// File: rtl/sem_cell.sv
module sem_cell (
  input  logic clk,
  input  logic rst,
  input  logic host_rd,
  input  logic host_rel,
  input  logic eng_take,
  input  logic eng_rel,
  output logic host_got,
  output logic eng_grant,
  output logic eng_refuse
);
  logic val_q;

  always_comb begin
    eng_grant  = eng_take & val_q;
    eng_refuse = eng_take & ~val_q;
    host_got   = host_rd & val_q & ~eng_take;
  end

  always_ff @(posedge clk) begin
    if (rst)                       val_q <= 1'b1;
    else if (eng_grant)            val_q <= 1'b0;
    else if (host_rel || eng_rel)  val_q <= 1'b1;
    else if (host_rd)              val_q <= 1'b0;
  end

  p_read_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !eng_rel) |=> !val_q);
  p_release_frees_r4: assert property (@(posedge clk) disable iff (rst)
    (host_rel && !eng_take) |=> val_q);
  p_grant_holds_r5: assert property (@(posedge clk) disable iff (rst)
    eng_grant |=> !val_q);
  p_refuse_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (eng_refuse && !host_rel && !eng_rel) |=> !val_q);
endmodule

// File: rtl/eng_seq.sv
module eng_seq
  import sem_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                task_start,
  input  logic                setup_done,
  input  logic                task_end,
  input  logic [ENG_SEMS-1:0] grant,
  output logic [ENG_SEMS-1:0] take_o,
  output logic [ENG_SEMS-1:0] rel_o
);
  logic [ENG_SEMS-1:0] held_q;

  always_comb begin
    take_o            = '0;
    take_o[START_IDX] = task_start & ~task_end;
    take_o[SETUP_IDX] = setup_done & ~task_end;
    rel_o             = task_end ? held_q : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)           held_q <= '0;
    else if (task_end) held_q <= '0;
    else               held_q <= held_q | grant;
  end

  p_end_drops_r6: assert property (@(posedge clk) disable iff (rst)
    task_end |=> (held_q == '0));
  p_refused_not_held_r7: assert property (@(posedge clk) disable iff (rst)
    (take_o[START_IDX] && !grant[START_IDX]) |=> (held_q[START_IDX] == $past(held_q[START_IDX])));
  p_grant_owned_r5: assert property (@(posedge clk) disable iff (rst)
    (grant[SETUP_IDX] && !task_end) |=> held_q[SETUP_IDX]);
endmodule

// File: rtl/host_port.sv
module host_port #(
  parameter int N_SEM  = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_SEM-1:0]  got,
  input  logic              err,
  output logic [N_SEM-1:0]  rd_sel,
  output logic [N_SEM-1:0]  rel_sel,
  output logic              stat_clr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(N_SEM);

  logic rd_bit;

  always_comb begin
    rd_sel   = '0;
    rel_sel  = '0;
    rd_bit   = 1'b0;
    for (int i = 0; i < N_SEM; i++) begin
      if (req && addr == ADDR_W'(i)) begin
        rd_sel[i]  = ~we;
        rel_sel[i] = we & wdata[0];
        rd_bit     = got[i];
      end
    end
    if (req && addr == STAT_ADDR) rd_bit = err;
    stat_clr = req & we & (addr == STAT_ADDR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= req & ~we;
      rdata  <= (req & ~we) ? {{(DATA_W-1){1'b0}}, rd_bit} : '0;
    end
  end

  p_rvalid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    (req && !we) |=> rvalid);
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (rdata[DATA_W-1:1] == '0));
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int N_SEM  = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  input  logic              task_start,
  input  logic              setup_done,
  input  logic              task_end,
  output logic              err_flag
);
  logic [N_SEM-1:0]    rd_sel, rel_sel, got, refuse;
  logic [ENG_SEMS-1:0] eng_take, eng_rel, eng_grant;
  logic                stat_clr, err_q;

  host_port #(.N_SEM(N_SEM), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst), .req(host_req), .we(host_we), .addr(host_addr),
    .wdata(host_wdata), .got(got), .err(err_q), .rd_sel(rd_sel),
    .rel_sel(rel_sel), .stat_clr(stat_clr), .rdata(host_rdata),
    .rvalid(host_rvalid)
  );

  eng_seq u_seq (
    .clk(clk), .rst(rst), .task_start(task_start), .setup_done(setup_done),
    .task_end(task_end), .grant(eng_grant), .take_o(eng_take), .rel_o(eng_rel)
  );

  for (genvar i = 0; i < N_SEM; i++) begin : g_sem
    if (i < ENG_SEMS) begin : g_shared
      sem_cell u_cell (
        .clk(clk), .rst(rst), .host_rd(rd_sel[i]), .host_rel(rel_sel[i]),
        .eng_take(eng_take[i]), .eng_rel(eng_rel[i]), .host_got(got[i]),
        .eng_grant(eng_grant[i]), .eng_refuse(refuse[i])
      );
    end else begin : g_host_only
      logic unused_grant;
      sem_cell u_cell (
        .clk(clk), .rst(rst), .host_rd(rd_sel[i]), .host_rel(rel_sel[i]),
        .eng_take(1'b0), .eng_rel(1'b0), .host_got(got[i]),
        .eng_grant(unused_grant), .eng_refuse(refuse[i])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             err_q <= 1'b0;
    else if (|refuse)    err_q <= 1'b1;
    else if (stat_clr)   err_q <= 1'b0;
  end

  assign err_flag = err_q;

  p_err_set_r7: assert property (@(posedge clk) disable iff (rst)
    (|refuse) |=> err_flag);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !stat_clr) |=> err_flag);
  p_err_cleared_r8: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !(|refuse)) |=> !err_flag);
endmodule

// File: tb/sim_sem_bank.sv
module sim_sem_bank;
  localparam int N_SEM = 3, DATA_W = 8, ADDR_W = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic host_req = 0, host_we = 0, task_start = 0, setup_done = 0, task_end = 0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [DATA_W-1:0] host_wdata = '0;
  logic [DATA_W-1:0] host_rdata;
  logic host_rvalid, err_flag;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sem_bank #(.N_SEM(N_SEM), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .task_start(task_start), .setup_done(setup_done),
    .task_end(task_end), .err_flag(err_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    host_req = 0; host_we = 0; task_start = 0; setup_done = 0; task_end = 0;
  endtask

  // drive at negedge, register at posedge, sample at following negedge
  task automatic rd(input int a, input int exp, input string req);
    @(negedge clk); host_req = 1; host_we = 0; host_addr = ADDR_W'(a);
    @(negedge clk); idle();
    chk({req, " rvalid"}, int'(host_rvalid), 1);
    chk(req, int'(host_rdata), exp);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); host_req = 1; host_we = 1; host_addr = ADDR_W'(a);
    host_wdata = DATA_W'(d);
    @(negedge clk); idle();
  endtask

  task automatic pulse(input logic s, input logic u, input logic e);
    @(negedge clk); task_start = s; setup_done = u; task_end = e;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    chk("R1 rdata", int'(host_rdata), 0);
    chk("R1 rvalid", int'(host_rvalid), 0);
    chk("R1 err", int'(err_flag), 0);
    chk("R11 err port", int'(err_flag), 0);
    for (int i = 0; i < N_SEM; i++) rd(i, 1, "R1 free at reset");
    for (int i = 0; i < N_SEM; i++) wr(i, 1);
  endtask

  task automatic t_take_release();
    rd(0, 1, "R2 take");
    rd(0, 0, "R2 held reads 0");
    wr(0, 1);
    rd(0, 1, "R4 release");
    wr(0, 1);
    rd(2, 1, "R2 take sem2");
    wr(2, 0);
    rd(2, 0, "R4 write 0 ignored");
    wr(2, 1);
    rd(2, 1, "R4 release sem2");
    wr(2, 1);
  endtask

  task automatic t_engine();
    pulse(1, 0, 0);
    chk("R5 no err on free take", int'(err_flag), 0);
    rd(0, 0, "R5 engine holds sem0");
    rd(0, 0, "R3 failed read no effect");
    chk("R3 err unchanged", int'(err_flag), 0);
    pulse(0, 1, 0);
    rd(1, 0, "R5 engine holds sem1");
    pulse(0, 0, 1);
    rd(0, 1, "R6 end frees sem0");
    rd(1, 1, "R6 end frees sem1");
    wr(0, 1); wr(1, 1);
  endtask

  task automatic t_refuse();
    rd(0, 1, "R7 host takes sem0");
    pulse(1, 0, 0);
    chk("R7 err set", int'(err_flag), 1);
    chk("R11 err port high", int'(err_flag), 1);
    rd(0, 0, "R7 host still owns");
    pulse(0, 0, 1);
    rd(0, 0, "R6 end leaves host sem");
    wr(0, 1);
    rd(0, 1, "R7 released by host");
    wr(0, 1);
    chk("R8 sticky", int'(err_flag), 1);
    rd(N_SEM, 1, "R8 status read");
    chk("R8 read keeps err", int'(err_flag), 1);
    wr(N_SEM, 0);
    chk("R8 clear", int'(err_flag), 0);
    rd(N_SEM, 0, "R8 status after clear");
  endtask

  task automatic t_set_beats_clear();
    rd(1, 1, "R8 host takes sem1");
    @(negedge clk); host_req = 1; host_we = 1; host_addr = ADDR_W'(N_SEM);
    host_wdata = '0; setup_done = 1;
    @(negedge clk); idle();
    chk("R8 set wins over clear", int'(err_flag), 1);
    wr(N_SEM, 0);
    chk("R8 cleared", int'(err_flag), 0);
    wr(1, 1);
  endtask

  task automatic t_host_only();
    rd(2, 1, "R10 host takes sem2");
    pulse(1, 0, 0); pulse(0, 1, 0); pulse(0, 0, 1);
    chk("R10 no err", int'(err_flag), 0);
    rd(2, 0, "R10 engine left sem2 held");
    wr(2, 1);
    rd(2, 1, "R10 host release");
    wr(2, 1);
  endtask

  task automatic t_end_with_start();
    pulse(1, 1, 1);
    rd(0, 1, "R6 no take with end");
    rd(1, 1, "R6 no setup take with end");
    wr(0, 1); wr(1, 1);
  endtask

  task automatic t_collision();
    @(negedge clk); host_req = 1; host_we = 0; host_addr = ADDR_W'(1);
    setup_done = 1;
    @(negedge clk); idle();
    chk("R9 host loses", int'(host_rdata), 0);
    chk("R9 no err", int'(err_flag), 0);
    rd(1, 0, "R9 engine owns");
    pulse(0, 0, 1);
    rd(1, 1, "R9 freed at end");
    wr(1, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_take_release();
        t_engine();
        t_refuse();
        t_set_beats_clear();
        t_host_only();
        t_end_with_start();
        t_collision();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule